// File: doc/BRIEF.md
# Configurable Low-Power Sleep Timer

This block is a 32-bit free-running sleep counter that moves one step per divided slow reference tick. Two slow references reach the block as single-cycle tick-enable pulses in the system clock domain. A configuration bit chooses one of them. A power-of-two prescaler then divides the chosen tick, and the counter steps up or down on each divided tick, wrapping modulo 2^32 in either direction.

Software reaches the block through a small register port. One word holds the configuration. Two more words return the upper and lower 16 bits of the count. The direction, prescaler and source fields are locked while the enable bit is set. The enable bit is re-timed by selected-tick events, so starting and stopping take effect a couple of slow ticks after the write. When debug pause is configured, a debug-halt input freezes counting.

Register map, by word address: 0 is configuration, 1 is count bits 31:16, 2 is count bits 15:0, and 3 reads as zero. Reads are combinational from `reg_addr`. A write takes effect on the clock edge where `reg_we` is high. These are plain control pins with no handshake, because every access completes in one cycle.

Top module: `lp_sleep_timer`

## Requirements
- R1: After reset, the configuration word reads 0x0000_0400 and both count halves read 0.
- R2: The configuration word has these fields: bit 0 is the source select, bits 7:4 are the prescaler exponent N, bit 10 is debug pause, bit 11 is enable and bit 12 is reverse. All other bits read 0, and address 3 reads 0.
- R3: While the stored enable bit is 1, a write leaves bits 0, 7:4 and 12 unchanged. Enable and debug pause accept every write.
- R4: Source select 0 counts `ref_tick_slow` pulses and ignores `ref_tick_fast`. Source select 1 does the opposite.
- R5: Take a write that sets enable with N=0. The first two selected ticks after it do not step the count, and the third tick does. After a write that clears enable, exactly two more selected ticks still step the count, and later ticks do not.
- R6: While running, the count steps once every 2^N selected ticks. The prescaler restarts from zero each time the timer stops.
- R7: With reverse 0, each step adds 1. With reverse 1, each step subtracts 1. Both directions wrap modulo 2^32.
- R8: When debug pause is 1 and `dbg_halt` is high, selected ticks neither step the count nor advance the prescaler. When debug pause is 0, `dbg_halt` has no effect.
- R9: Address 1 returns count bits 31:16 and address 2 returns count bits 15:0, both zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_slow | input | 1 | One-cycle tick from the calibrated 1 kHz reference |
| ref_tick_fast | input | 1 | One-cycle tick from the 32 kHz reference |
| dbg_halt | input | 1 | High while the processor is halted in debug |
| reg_we | input | 1 | Write strobe for the configuration word |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |

## Verification
The hardest state to reach from the ports is the window in which the configured enable bit and the internally re-timed run state disagree. The count moves in that window even though software already sees the new setting. The bench drives selected ticks one at a time and reads the count after each group. This pins down exactly the two ticks that do not count after starting and the two that still count after stopping. It then repeats the check with a prescaler phase left part-way so that the drain ticks land short of an advance. Wrap-around in both directions is reached cheaply by a reset followed by counting down from zero.

// File: rtl/lp_sleep_timer_pkg.sv
package lp_sleep_timer_pkg;
  localparam int CNT_W   = 32;
  localparam int HALF_W  = CNT_W / 2;
  localparam int DIV_W   = 4;
  localparam int PRE_W   = (1 << DIV_W) - 1;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  localparam int B_SRC   = 0;
  localparam int B_DIVLO = 4;
  localparam int B_PAUSE = 10;
  localparam int B_EN    = 11;
  localparam int B_REV   = 12;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 2'd0,
    A_HIGH = 2'd1,
    A_LOW  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             rev;
    logic             en;
    logic             pause;
    logic [DIV_W-1:0] div;
    logic             src;
  } cfg_t;
endpackage

// File: rtl/lpst_cfg_regs.sv
module lpst_cfg_regs
  import lp_sleep_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{rev: 1'b0, en: 1'b0, pause: 1'b1, div: '0, src: 1'b0};
    end else if (wr_cfg) begin
      cfg_q.en    <= wdata[B_EN];
      cfg_q.pause <= wdata[B_PAUSE];
      if (!cfg_q.en) begin
        cfg_q.rev <= wdata[B_REV];
        cfg_q.div <= wdata[B_DIVLO +: DIV_W];
        cfg_q.src <= wdata[B_SRC];
      end
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lpst_tick_path.sv
module lpst_tick_path
  import lp_sleep_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             src_sel,
  input  logic             en_cfg,
  input  logic [DIV_W-1:0] div_n,
  input  logic             pause_cfg,
  input  logic             halt,
  output logic             sel_tick,
  output logic             run,
  output logic             adv
);
  logic [1:0]       en_sync;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             step;

  assign sel_tick = src_sel ? tick_fast : tick_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_sync <= '0;
    else if (sel_tick) en_sync <= {en_sync[0], en_cfg};
  end

  assign run  = en_sync[1];
  assign step = run && sel_tick && !(pause_cfg && halt);

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (32'(div_n) > i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (!run) pre_q <= '0;
    else if (step) pre_q <= pre_q + PRE_W'(1);
  end

  assign adv = step && ((pre_q & mask) == mask);
endmodule

// File: rtl/lpst_counter.sv
module lpst_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         down,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= down ? cnt_q - W'(1) : cnt_q + W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lp_sleep_timer.sv
module lp_sleep_timer
  import lp_sleep_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_slow,
  input  logic              ref_tick_fast,
  input  logic              dbg_halt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  cfg_t             cfg;
  logic             sel_tick;
  logic             run;
  logic             adv;
  logic [CNT_W-1:0] count;
  logic             wr_cfg;

  assign wr_cfg = reg_we && (reg_addr == A_CFG);

  lpst_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_cfg(wr_cfg),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  lpst_tick_path u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_slow(ref_tick_slow),
    .tick_fast(ref_tick_fast),
    .src_sel  (cfg.src),
    .en_cfg   (cfg.en),
    .div_n    (cfg.div),
    .pause_cfg(cfg.pause),
    .halt     (dbg_halt),
    .sel_tick (sel_tick),
    .run      (run),
    .adv      (adv)
  );

  lpst_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (adv),
    .down (cfg.rev),
    .cnt  (count)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: begin
        reg_rdata[B_SRC]               = cfg.src;
        reg_rdata[B_DIVLO +: DIV_W]    = cfg.div;
        reg_rdata[B_PAUSE]             = cfg.pause;
        reg_rdata[B_EN]                = cfg.en;
        reg_rdata[B_REV]               = cfg.rev;
      end
      A_HIGH:  reg_rdata[HALF_W-1:0]   = count[CNT_W-1:HALF_W];
      A_LOW:   reg_rdata[HALF_W-1:0]   = count[HALF_W-1:0];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpst_checker.sv
module lpst_checker
  import lp_sleep_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              dbg_halt,
  input cfg_t              cfg,
  input logic              sel_tick,
  input logic              run,
  input logic              adv,
  input logic [CNT_W-1:0]  count
);
  localparam logic [DATA_W-1:0] USED =
    (DATA_W'(1) << B_SRC) | (DATA_W'((1 << DIV_W) - 1) << B_DIVLO) |
    (DATA_W'(1) << B_PAUSE) | (DATA_W'(1) << B_EN) | (DATA_W'(1) << B_REV);

  always_comb begin
    if (rst_n && reg_addr == A_CFG)
      assert_unused_zero_R2: assert ((reg_rdata & ~USED) == '0);
  end

  assert_locked_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CFG && cfg.en) |=> $stable({cfg.rev, cfg.div, cfg.src}));

  assert_other_tick_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> $stable(count));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (count == ($past(cfg.rev) ? $past(count) - CNT_W'(1) : $past(count) + CNT_W'(1))));

  assert_debug_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pause && dbg_halt) |=> $stable(count));
endmodule

bind lp_sleep_timer lpst_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .dbg_halt (dbg_halt),
  .cfg      (cfg),
  .sel_tick (sel_tick),
  .run      (run),
  .adv      (adv),
  .count    (count)
);

// File: tb/lp_sleep_timer_test.sv
`timescale 1ns/1ps
module lp_sleep_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tk_slow = 1'b0, tk_fast = 1'b0, halt = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_checks = 0, n_fail = 0;

  localparam logic [31:0] EN = 32'h800, REV = 32'h1000, PAU = 32'h400, SRC = 32'h1;

  lp_sleep_timer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick_slow(tk_slow), .ref_tick_fast(tk_fast),
    .dbg_halt(halt), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); addr = 2'd0; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic ticks(bit fast, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (fast) tk_fast = 1'b1; else tk_slow = 1'b1;
      @(negedge clk); tk_fast = 1'b0; tk_slow = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic chk_cnt(string tag, logic [31:0] exp);
    logic [31:0] h, l;
    rd(2'd1, h); rd(2'd2, l);
    check(tag, {h[15:0], l[15:0]}, exp);
    check({tag, " upper bits zero"}, {h[31:16], l[31:16]}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 cfg reset", d, 32'h400);
    chk_cnt("R1 count reset", 32'h0);
    rd(2'd3, d); check("R2 addr3 zero", d, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(32'hFFFF_F7FF); rd(2'd0, d); check("R2 field layout", d, 32'h14F1);
    wr(PAU); rd(2'd0, d); check("R2 restore", d, 32'h400);
  endtask

  task automatic t_enable();
    wr(EN);
    ticks(1, 3); chk_cnt("R4 fast ignored when slow chosen", 0);
    ticks(0, 2); chk_cnt("R5 two ticks of start latency", 0);
    ticks(0, 1); chk_cnt("R5 third tick counts", 1);
    ticks(0, 3); chk_cnt("R9 low half", 4);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(EN | REV | 32'hA0 | SRC); rd(2'd0, d); check("R3 locked fields", d, EN);
    ticks(0, 2); chk_cnt("R3 still up on slow", 6);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    wr(EN | PAU); rd(2'd0, d); check("R3 pause writable while enabled", d, EN | PAU);
    halt = 1'b1; ticks(0, 3); chk_cnt("R8 frozen by halt", 6);
    wr(EN); ticks(0, 2); chk_cnt("R8 halt ignored without pause", 8);
    halt = 1'b0;
  endtask

  task automatic t_disable();
    wr(32'h0);
    ticks(0, 2); chk_cnt("R5 two drain ticks", 10);
    ticks(0, 3); chk_cnt("R5 stopped", 10);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(EN | 32'h20); rd(2'd0, d); check("R3 fields writable when off", d, EN | 32'h20);
    ticks(0, 2); chk_cnt("R6 sync window", 10);
    ticks(0, 3); chk_cnt("R6 no advance before 4", 10);
    ticks(0, 1); chk_cnt("R6 advance on 4th", 11);
    ticks(0, 8); chk_cnt("R6 two more", 13);
    wr(32'h20); ticks(0, 4); chk_cnt("R6 drain short of advance", 13);
  endtask

  task automatic t_fast();
    wr(EN | SRC);
    ticks(1, 2); chk_cnt("R4 sync on fast", 13);
    ticks(0, 3); chk_cnt("R4 slow ignored when fast chosen", 13);
    ticks(1, 1); chk_cnt("R4 fast counts", 14);
    wr(SRC); ticks(1, 2); chk_cnt("R4 fast drain", 16);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    do_reset();
    wr(EN | REV);
    ticks(0, 2); chk_cnt("R7 sync", 0);
    ticks(0, 1); chk_cnt("R7 down wrap", 32'hFFFF_FFFF);
    rd(2'd1, d); check("R9 high half", d, 32'h0000_FFFF);
    ticks(0, 1); chk_cnt("R7 down step", 32'hFFFF_FFFE);
    wr(REV); ticks(0, 2); chk_cnt("R7 down drain", 32'hFFFF_FFFC);
    wr(EN); ticks(0, 2); ticks(0, 4); chk_cnt("R7 up wrap", 32'h0);
    ticks(0, 1); chk_cnt("R7 up after wrap", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_layout(); t_enable(); t_lock(); t_pause();
    t_disable(); t_prescale(); t_fast(); t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule